// File: doc/BRIEF.md
# Bus-Inactivity Auto Power-Down Controller

This block watches the address strobe of a microcontroller bus and drops an attached memory and logic peripheral into a low-power state once the strobe has been quiet for a fixed number of periods of a free-running input clock. The strobe and the active-low chip select are brought into that clock domain through two-flop synchronizers. Any change in the synchronized strobe counts as activity. A 4-bit inactivity counter climbs on every quiet period. When it saturates, the power-down flag rises.

While power-down is active, the block turns off the bus interface enable and forces every memory select low. The data-port and peripheral output enables are forced low, so those pins go tri-state. The MCU I/O enables pass through unchanged. Three things wake the block: renewed strobe activity, chip select low, or reset. Clearing the enable bit returns it to the disabled state on the next edge. A separate clock-mask input removes the clock from the downstream logic array, but it never stops the inactivity counter.

The controller is a three-state machine:
- **IDLE**: unit disabled, counter held at 0.
- **WATCH**: counting quiet periods.
- **DOWN**: power-down active.

The transitions are:
- IDLE→WATCH when enabled (counter 0).
- WATCH→WATCH counting up on a quiet period, or cleared on a wake event.
- WATCH→DOWN on the quiet period that brings the counter to 15.
- DOWN→WATCH on a wake event (counter cleared).
- Any state→IDLE when the enable is low.

Top module: `apd_ctrl`

## Requirements
- R1: With `apd_en_i` low at a clock edge, the block is in IDLE after that edge: `pd_o` is 0 and the counter is 0. From DOWN, `pd_o` falls on the first edge that sees the enable low.
- R2: Strobe and chip select each pass through two synchronizer flops. The counter advances by one on each edge at which the synchronized strobe did not change since the previous sample. A change in either direction clears the counter to 0.
- R3: `pd_o` rises on the edge where the counter reaches 15, which is the fifteenth consecutive quiet sample. The counter then stays at 15; it does not wrap.
- R4: While `pd_o` is high, a change in the synchronized strobe clears `pd_o` and the counter on the next edge.
- R5: A synchronized low on `cs_n_i` clears `pd_o` and the counter.
- R6: `rst_i` high clears all state asynchronously, so `pd_o` goes to 0 at once. Release is synchronized: the state machine first acts on the third rising edge after `rst_i` falls.
- R7: While `pd_o` is high, `bus_en_o` is 0 and all bits of `mem_sel_o` are 0 (bit 0 flash, bit 1 EEPROM, bit 2 SRAM). Otherwise `bus_en_o` is 1 and `mem_sel_o` equals `mem_sel_i`.
- R8: While `pd_o` is high, `data_oe_o` and `periph_oe_o` are all 0 (tri-state). `mcu_oe_o` always equals `mcu_oe_i`. Outside power-down, the data and peripheral enables follow their inputs.
- R9: `logic_clk_en_o` is the inverse of `clk_mask_i`. The mask has no effect on counting or on `pd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock that paces the counter |
| rst_i | input | 1 | Reset, active high, asynchronous assert |
| apd_en_i | input | 1 | Auto power-down enable (mode register bit) |
| strobe_i | input | 1 | Bus address strobe, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| clk_mask_i | input | 1 | Blocks the input clock from the logic array |
| mem_sel_i | input | 3 | Memory selects from decode: flash, EEPROM, SRAM |
| data_oe_i | input | 8 | Data port output enables |
| periph_oe_i | input | 8 | Peripheral I/O output enables |
| mcu_oe_i | input | 8 | MCU I/O output enables |
| pd_o | output | 1 | Power-down flag |
| bus_en_o | output | 1 | Bus interface enable |
| mem_sel_o | output | 3 | Gated memory selects |
| data_oe_o | output | 8 | Gated data port output enables |
| periph_oe_o | output | 8 | Gated peripheral output enables |
| mcu_oe_o | output | 8 | MCU I/O output enables, passed through |
| logic_clk_en_o | output | 1 | Clock enable toward the logic array |

## Verification
The assertions check on every cycle these invariants:
- the enable clear;
- the counter step on a quiet sample;
- that power-down implies a full counter;
- that either wake source clears the flag on the next edge;
- the forced-off state of selects and enables.

The exact edge on which power-down rises after a run of quiet samples can only be shown by the bench scenarios. The same holds for the three-edge reset release latency, for a partial count being restarted by a single strobe change, and for the independence of the clock mask from counting. The bench compares its behavioural model against every output on every clock to cover these cases.

// File: rtl/apd_pkg.sv
package apd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_DOWN  = 2'd2
    } apd_state_t;
endpackage

// File: rtl/apd_reset_sync.sv
module apd_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/apd_activity.sv
module apd_activity #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic strobe_i,
    input  logic cs_n_i,
    output logic strobe_act_o,
    output logic cs_low_o
);
    logic [SYNC_STAGES-1:0] strobe_q;
    logic [SYNC_STAGES-1:0] cs_q;
    logic                   strobe_prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk_i or negedge rst_n_i) begin
                if (!rst_n_i) begin
                    strobe_q[g] <= 1'b0;
                    cs_q[g]     <= 1'b1;
                end else if (g == 0) begin
                    strobe_q[g] <= strobe_i;
                    cs_q[g]     <= cs_n_i;
                end else begin
                    strobe_q[g] <= strobe_q[(g == 0) ? 0 : g-1];
                    cs_q[g]     <= cs_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) strobe_prev_q <= 1'b0;
        else          strobe_prev_q <= strobe_q[SYNC_STAGES-1];
    end

    assign strobe_act_o = strobe_q[SYNC_STAGES-1] ^ strobe_prev_q;
    assign cs_low_o     = ~cs_q[SYNC_STAGES-1];
endmodule

// File: rtl/apd_fsm.sv
module apd_fsm
    import apd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic strobe_act_i,
    input  logic cs_low_i,
    output logic pd_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = '1;

    apd_state_t       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             wake;

    assign wake = strobe_act_i | cs_low_i;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_n = '0;
                if (en_i) st_n = ST_WATCH;
            end
            ST_WATCH: begin
                if (!en_i) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else if (wake) begin
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == CNT_FULL - 1'b1) st_n = ST_DOWN;
                end
            end
            ST_DOWN: begin
                if (!en_i) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else if (wake) begin
                    st_n  = ST_WATCH;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        pd_o = (st_q == ST_DOWN);
    end

    p_off_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_i |=> (!pd_o && cnt_q == '0));
    p_quiet_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q == ST_WATCH && en_i && !wake) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_full_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_o |-> (cnt_q == CNT_FULL));
    p_strobe_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (pd_o && strobe_act_i) |=> (!pd_o && cnt_q == '0));
    p_cs_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cs_low_i |=> (!pd_o && cnt_q == '0));
endmodule

// File: rtl/apd_gate.sv
module apd_gate #(
    parameter int SEL_W  = 3,
    parameter int DATA_W = 8,
    parameter int PER_W  = 8,
    parameter int MCU_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              pd_i,
    input  logic              clk_mask_i,
    input  logic [SEL_W-1:0]  mem_sel_i,
    input  logic [DATA_W-1:0] data_oe_i,
    input  logic [PER_W-1:0]  periph_oe_i,
    input  logic [MCU_W-1:0]  mcu_oe_i,
    output logic              bus_en_o,
    output logic [SEL_W-1:0]  mem_sel_o,
    output logic [DATA_W-1:0] data_oe_o,
    output logic [PER_W-1:0]  periph_oe_o,
    output logic [MCU_W-1:0]  mcu_oe_o,
    output logic              logic_clk_en_o
);
    always_comb begin
        bus_en_o       = ~pd_i;
        mem_sel_o      = pd_i ? '0 : mem_sel_i;
        data_oe_o      = pd_i ? '0 : data_oe_i;
        periph_oe_o    = pd_i ? '0 : periph_oe_i;
        mcu_oe_o       = mcu_oe_i;
        logic_clk_en_o = ~clk_mask_i;
    end

    p_sel_off_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_i |-> (mem_sel_o == '0 && !bus_en_o));
    p_sel_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !pd_i |-> (mem_sel_o == mem_sel_i && bus_en_o));
    p_tri_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_i |-> (data_oe_o == '0 && periph_oe_o == '0));
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 3,
    parameter int DATA_W      = 8,
    parameter int PER_W       = 8,
    parameter int MCU_W       = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              apd_en_i,
    input  logic              strobe_i,
    input  logic              cs_n_i,
    input  logic              clk_mask_i,
    input  logic [SEL_W-1:0]  mem_sel_i,
    input  logic [DATA_W-1:0] data_oe_i,
    input  logic [PER_W-1:0]  periph_oe_i,
    input  logic [MCU_W-1:0]  mcu_oe_i,
    output logic              pd_o,
    output logic              bus_en_o,
    output logic [SEL_W-1:0]  mem_sel_o,
    output logic [DATA_W-1:0] data_oe_o,
    output logic [PER_W-1:0]  periph_oe_o,
    output logic [MCU_W-1:0]  mcu_oe_o,
    output logic              logic_clk_en_o
);
    logic rst_n;
    logic strobe_act;
    logic cs_low;
    logic pd;

    apd_reset_sync #(.STAGES(2)) u_rst (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .rst_n_o(rst_n)
    );

    apd_activity #(.SYNC_STAGES(SYNC_STAGES)) u_act (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n),
        .strobe_i    (strobe_i),
        .cs_n_i      (cs_n_i),
        .strobe_act_o(strobe_act),
        .cs_low_o    (cs_low)
    );

    apd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n),
        .en_i        (apd_en_i),
        .strobe_act_i(strobe_act),
        .cs_low_i    (cs_low),
        .pd_o        (pd)
    );

    apd_gate #(
        .SEL_W (SEL_W),
        .DATA_W(DATA_W),
        .PER_W (PER_W),
        .MCU_W (MCU_W)
    ) u_gate (
        .clk_i         (clk_i),
        .rst_n_i       (rst_n),
        .pd_i          (pd),
        .clk_mask_i    (clk_mask_i),
        .mem_sel_i     (mem_sel_i),
        .data_oe_i     (data_oe_i),
        .periph_oe_i   (periph_oe_i),
        .mcu_oe_i      (mcu_oe_i),
        .bus_en_o      (bus_en_o),
        .mem_sel_o     (mem_sel_o),
        .data_oe_o     (data_oe_o),
        .periph_oe_o   (periph_oe_o),
        .mcu_oe_o      (mcu_oe_o),
        .logic_clk_en_o(logic_clk_en_o)
    );

    assign pd_o = pd;

    p_async_clear_r6: assert property (@(posedge clk_i) !rst_n |-> !pd_o);
endmodule

// File: tb/apd_ctrl_tb_top.sv
module apd_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, strobe = 1'b0, cs_n = 1'b1, mask = 1'b0;
    logic [2:0] sel_i = 3'b101;
    logic [7:0] doe_i = 8'hA5, poe_i = 8'h3C, moe_i = 8'h5A;
    logic       pd, bus_en, lce;
    logic [2:0] sel_o;
    logic [7:0] doe_o, poe_o, moe_o;

    int tests = 0, fails = 0;
    string tag = "R6";

    always #10 clk = ~clk;

    apd_ctrl dut_i (
        .clk_i(clk), .rst_i(rst), .apd_en_i(en), .strobe_i(strobe), .cs_n_i(cs_n),
        .clk_mask_i(mask), .mem_sel_i(sel_i), .data_oe_i(doe_i), .periph_oe_i(poe_i),
        .mcu_oe_i(moe_i), .pd_o(pd), .bus_en_o(bus_en), .mem_sel_o(sel_o),
        .data_oe_o(doe_o), .periph_oe_o(poe_o), .mcu_oe_o(moe_o), .logic_clk_en_o(lce)
    );

    // Behavioural reference model
    int  rel_edges;
    bit  m_idle, m_pd;
    int  m_cnt;
    bit  sq[$];
    bit  cq[$];

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            rel_edges = 0; m_idle = 1; m_pd = 0; m_cnt = 0;
            sq = '{0, 0, 0};
            cq = '{1, 1};
        end else begin
            rel_edges++;
            if (rel_edges >= 3) begin
                bit act, csl;
                act = (sq[1] != sq[2]);
                csl = (cq[1] == 0);
                if (!en) begin m_idle = 1; m_cnt = 0; m_pd = 0; end
                else if (m_idle) begin m_idle = 0; m_cnt = 0; m_pd = 0; end
                else if (act || csl) begin m_cnt = 0; m_pd = 0; end
                else if (!m_pd) begin
                    m_cnt++;
                    if (m_cnt == 15) m_pd = 1;
                end
                sq.push_front(strobe); void'(sq.pop_back());
                cq.push_front(cs_n);   void'(cq.pop_back());
            end
        end
    end

    task automatic check(string t, longint got, longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
        end
    endtask

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check({tag, " pd"}, pd, m_pd);
            check("R7 bus_en", bus_en, !m_pd);
            check("R7 mem_sel", sel_o, m_pd ? 3'b0 : sel_i);
            check("R8 data_oe", doe_o, m_pd ? 8'h0 : doe_i);
            check("R8 periph_oe", poe_o, m_pd ? 8'h0 : poe_i);
            check("R8 mcu_oe", moe_o, moe_i);
            check("R9 clk_en", lce, !mask);
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic toggle(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); strobe = ~strobe; end
    endtask

    initial begin
        cycles(3);
        check("R6 reset pd", pd, 0);
        check("R6 reset bus_en", bus_en, 1);
        rst = 1'b0;
        cycles(5);
        check("R6 after release pd", pd, 0);

        tag = "R2"; en = 1'b1;
        toggle(25);
        check("R2 busy strobe no pd", pd, 0);
        cycles(10); toggle(1); cycles(10);
        check("R2 restart partial count", pd, 0);

        tag = "R3"; cycles(12);
        check("R3 quiet reaches power-down", pd, 1);
        cycles(10);
        check("R3 stays down saturated", pd, 1);
        check("R7 selects forced off", sel_o, 0);
        check("R8 data tri-state", doe_o, 0);

        tag = "R4"; toggle(1); cycles(4);
        check("R4 strobe activity wakes", pd, 0);

        tag = "R5"; cycles(20);
        check("R5 down before cs", pd, 1);
        cs_n = 1'b0; @(negedge clk); cs_n = 1'b1; cycles(3);
        check("R5 cs low wakes", pd, 0);

        tag = "R9"; mask = 1'b1; cycles(20);
        check("R9 mask does not stop count", pd, 1);
        check("R9 logic clock gated", lce, 0);
        mask = 1'b0;

        tag = "R1"; en = 1'b0; @(negedge clk);
        check("R1 disable drops pd", pd, 0);
        cycles(25);
        check("R1 stays off", pd, 0);
        en = 1'b1; cycles(20);

        tag = "R6"; check("R6 down before reset", pd, 1);
        @(posedge clk); #3 rst = 1'b1; #1;
        check("R6 async clear", pd, 0);
        cycles(2); rst = 1'b0; cycles(25);
        check("R6 down again after release", pd, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule